// File: doc/BRIEF.md
# Character Input and Output Device Registers

This block holds the four device registers that a processor uses for character traffic with a keyboard and a display. Each device has a status word and a data word. An address decoder elsewhere turns processor loads and stores into a one-hot register select, a read strobe, a write strobe and a write word. The keyboard side delivers a strobe with an 8-bit character each time a key is struck. The display side returns a strobe when it has finished with the last character.

The handshake runs through ready flags. Storing a struck key raises the keyboard flag, and a processor read of the keyboard data word drops it again. A store to the display data word drops the display flag and sends the character out as a one-cycle valid pulse. The display's done strobe raises the flag again. Each device raises an interrupt request whenever its enable bit and its ready flag are both set. Software can change only the enable bits.

Top module: `char_io_regs`

## Requirements
- R1: After reset the keyboard ready flag is 0, the display ready flag is 1, both enable bits are 0, both interrupt requests are 0 and `disp_valid` is 0.
- R2: A `key_stb` cycle stores `key_char`. From the next cycle on, the keyboard data word reads {8'h00, character} and keyboard status bit 15 (ready) reads 1.
- R3: A cycle with `rd_stb` and the keyboard data select (`reg_sel` bit 1) set, and no key strike, clears the keyboard ready flag from the next cycle on.
- R4: When a key strike and a read of the keyboard data word fall in the same cycle, the new character is stored and the keyboard ready flag ends up set.
- R5: A cycle with `wr_stb` and the display data select (`reg_sel` bit 3) set makes `disp_valid` high for exactly the next cycle, with `disp_char` equal to `wr_data[7:0]`. It also clears the display ready flag (status bit 15).
- R6: A `disp_done` cycle sets the display ready flag from the next cycle on. If a display data write falls in the same cycle, the write wins and the flag ends up 0.
- R7: A write to a status word (keyboard `reg_sel` bit 0, display `reg_sel` bit 2) copies `wr_data[14]` into that device's enable bit and leaves its ready flag unchanged.
- R8: `kbd_irq` and `dsp_irq` are each 1 exactly when that device's enable bit and ready flag are both 1.
- R9: `rd_data` shows the selected register in the same cycle. Status words read {ready, enable, 14'b0}, data words read {8'h00, character}, and `rd_data` is 0 when no select is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 4 | One-hot select: bit0 keyboard status, bit1 keyboard data, bit2 display status, bit3 display data |
| rd_stb | input | 1 | Processor read of the selected register this cycle |
| wr_stb | input | 1 | Processor write of the selected register this cycle |
| wr_data | input | 16 | Write word |
| rd_data | output | 16 | Read word of the selected register |
| key_stb | input | 1 | Key strike strobe |
| key_char | input | 8 | Character of the key strike |
| disp_done | input | 1 | Display finished with the last character |
| disp_valid | output | 1 | One-cycle pulse: `disp_char` is a new character |
| disp_char | output | 8 | Character sent to the display |
| kbd_irq | output | 1 | Keyboard interrupt request |
| dsp_irq | output | 1 | Display interrupt request |

## Verification
The assertions assume that `reg_sel` has at most one bit set and that `rd_stb` and `wr_stb` never rise in the same cycle, which is what a load/store decoder produces. The stimulus tasks move one select bit at a time and raise either the read strobe or the write strobe, never both. Collisions are created only between a processor access and a device strobe (key strike with read, display write with done), since the block orders those itself.

// File: rtl/char_io_pkg.sv
// Package: shared select indices and status layout for the character I/O registers.
// Assumes: reg_sel is one-hot or zero.
package char_io_pkg;
    localparam int SEL_KSTAT = 0;
    localparam int SEL_KDATA = 1;
    localparam int SEL_DSTAT = 2;
    localparam int SEL_DDATA = 3;
    localparam int NUM_REGS  = 4;

    // Status flags of one device.
    typedef struct packed {
        logic rdy;
        logic ie;
    } dev_stat_t;
endpackage

// File: rtl/char_io_kbd.sv
// Keyboard side: captures struck characters, keeps the ready flag and the enable bit.
// Assumes: a key strike and a clearing read in one cycle leave the flag set.
module char_io_kbd #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_stb,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              data_rd,
    input  logic              ie_wr,
    input  logic              ie_val,
    output char_io_pkg::dev_stat_t stat,
    output logic [CHAR_W-1:0] chr,
    output logic              irq
);
    logic rdy_q;
    logic ie_q;
    logic [CHAR_W-1:0] chr_q;

    // Character holding register, loaded on every key strike.
    always_ff @(posedge clk) begin
        if (!rst_n)       chr_q <= '0;
        else if (key_stb) chr_q <= key_char;
    end

    // Ready flag: strike sets, read of the data word clears, strike wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdy_q <= 1'b0;
        else if (key_stb) rdy_q <= 1'b1;
        else if (data_rd) rdy_q <= 1'b0;
    end

    // Enable bit, the only software-writable status field.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= 1'b0;
        else if (ie_wr) ie_q <= ie_val;
    end

    // Outputs toward the read path and the interrupt logic.
    always_comb begin
        stat.rdy = rdy_q;
        stat.ie  = ie_q;
        chr      = chr_q;
        irq      = rdy_q & ie_q;
    end
endmodule

// File: rtl/char_io_dsp.sv
// Display side: sends written characters out as a one-cycle pulse, keeps the ready flag and the enable bit.
// Assumes: a character write and a done strobe in one cycle leave the flag clear.
module char_io_dsp #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] data_val,
    input  logic              done,
    input  logic              ie_wr,
    input  logic              ie_val,
    output char_io_pkg::dev_stat_t stat,
    output logic [CHAR_W-1:0] chr,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char,
    output logic              irq
);
    logic rdy_q;
    logic ie_q;
    logic vld_q;
    logic [CHAR_W-1:0] chr_q;

    // Character register, loaded by a processor write.
    always_ff @(posedge clk) begin
        if (!rst_n)       chr_q <= '0;
        else if (data_wr) chr_q <= data_val;
    end

    // Valid pulse, high for the cycle after a write.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= data_wr;
    end

    // Ready flag: idle after reset, a write clears it, done sets it, the write wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdy_q <= 1'b1;
        else if (data_wr) rdy_q <= 1'b0;
        else if (done)    rdy_q <= 1'b1;
    end

    // Enable bit, the only software-writable status field.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= 1'b0;
        else if (ie_wr) ie_q <= ie_val;
    end

    // Outputs toward the display, the read path and the interrupt logic.
    always_comb begin
        stat.rdy  = rdy_q;
        stat.ie   = ie_q;
        chr       = chr_q;
        out_valid = vld_q;
        out_char  = chr_q;
        irq       = rdy_q & ie_q;
    end
endmodule

// File: rtl/char_io_rdmux.sv
// Read path: forms the selected register word with zero-filled unused bits.
// Assumes: sel is one-hot or zero; zero reads as all zeros.
module char_io_rdmux #(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic [char_io_pkg::NUM_REGS-1:0] sel,
    input  char_io_pkg::dev_stat_t           k_stat,
    input  logic [CHAR_W-1:0]                k_chr,
    input  char_io_pkg::dev_stat_t           d_stat,
    input  logic [CHAR_W-1:0]                d_chr,
    output logic [DATA_W-1:0]                rd_data
);
    localparam int STAT_PAD = DATA_W - 2;
    localparam int DATA_PAD = DATA_W - CHAR_W;

    logic [DATA_W-1:0] words [char_io_pkg::NUM_REGS];

    // Register words in select order.
    always_comb begin
        words[char_io_pkg::SEL_KSTAT] = {k_stat.rdy, k_stat.ie, {STAT_PAD{1'b0}}};
        words[char_io_pkg::SEL_KDATA] = {{DATA_PAD{1'b0}}, k_chr};
        words[char_io_pkg::SEL_DSTAT] = {d_stat.rdy, d_stat.ie, {STAT_PAD{1'b0}}};
        words[char_io_pkg::SEL_DDATA] = {{DATA_PAD{1'b0}}, d_chr};
    end

    // AND-OR selection of the one-hot select.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < char_io_pkg::NUM_REGS; i++) begin
            rd_data = rd_data | (words[i] & {DATA_W{sel[i]}});
        end
    end
endmodule

// File: rtl/char_io_regs.sv
// Top: keyboard and display device registers behind a decoded select bus.
// Assumes: reg_sel is one-hot or zero; rd_stb and wr_stb are never set together.
module char_io_regs #(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [char_io_pkg::NUM_REGS-1:0] reg_sel,
    input  logic                             rd_stb,
    input  logic                             wr_stb,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [DATA_W-1:0]                rd_data,
    input  logic                             key_stb,
    input  logic [CHAR_W-1:0]                key_char,
    input  logic                             disp_done,
    output logic                             disp_valid,
    output logic [CHAR_W-1:0]                disp_char,
    output logic                             kbd_irq,
    output logic                             dsp_irq
);
    import char_io_pkg::*;

    localparam int IE_BIT = DATA_W - 2;

    logic      k_data_rd, k_ie_wr, d_data_wr, d_ie_wr;
    dev_stat_t k_stat, d_stat;
    logic      k_rdy, k_ie, d_rdy, d_ie;
    logic [CHAR_W-1:0] k_chr, d_chr;

    // Decoded access strobes per register.
    always_comb begin
        k_data_rd = rd_stb & reg_sel[SEL_KDATA];
        k_ie_wr   = wr_stb & reg_sel[SEL_KSTAT];
        d_ie_wr   = wr_stb & reg_sel[SEL_DSTAT];
        d_data_wr = wr_stb & reg_sel[SEL_DDATA];
        k_rdy     = k_stat.rdy;
        k_ie      = k_stat.ie;
        d_rdy     = d_stat.rdy;
        d_ie      = d_stat.ie;
    end

    char_io_kbd #(.CHAR_W(CHAR_W)) u_kbd (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_stb  (key_stb),
        .key_char (key_char),
        .data_rd  (k_data_rd),
        .ie_wr    (k_ie_wr),
        .ie_val   (wr_data[IE_BIT]),
        .stat     (k_stat),
        .chr      (k_chr),
        .irq      (kbd_irq)
    );

    char_io_dsp #(.CHAR_W(CHAR_W)) u_dsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (d_data_wr),
        .data_val  (wr_data[CHAR_W-1:0]),
        .done      (disp_done),
        .ie_wr     (d_ie_wr),
        .ie_val    (wr_data[IE_BIT]),
        .stat      (d_stat),
        .chr       (d_chr),
        .out_valid (disp_valid),
        .out_char  (disp_char),
        .irq       (dsp_irq)
    );

    char_io_rdmux #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_rdmux (
        .sel     (reg_sel),
        .k_stat  (k_stat),
        .k_chr   (k_chr),
        .d_stat  (d_stat),
        .d_chr   (d_chr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/char_io_regs_chk.sv
// Checker: temporal properties of the character I/O registers, bound to the top.
// Assumes: the input rules stated in the top module header.
module char_io_regs_chk #(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        reg_sel,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data,
    input logic              key_stb,
    input logic              disp_done,
    input logic              disp_valid,
    input logic [CHAR_W-1:0] disp_char,
    input logic              kbd_irq,
    input logic              k_rdy,
    input logic              k_ie,
    input logic              d_rdy
);
    // Key strike always leaves the flag set (R2, R4).
    assert_key_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        key_stb |=> k_rdy);

    // Data read without a strike clears the flag (R3).
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && reg_sel[1] && !key_stb) |=> !k_rdy);

    // Display write gives a pulse with the written character (R5).
    assert_pulse_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && reg_sel[3]) |=> (disp_valid && !d_rdy && disp_char == $past(wr_data[CHAR_W-1:0])));

    // No pulse without a write in the cycle before (R5).
    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> $past(wr_stb && reg_sel[3]));

    // Done without a write sets the display flag (R6).
    assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_done && !(wr_stb && reg_sel[3])) |=> d_rdy);

    // Enable changes only through a status write (R7).
    assert_ie_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && reg_sel[0]) |=> $stable(k_ie));

    // Request rises only after a strike or an enable write (R8).
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kbd_irq) |-> ($past(key_stb) || $past(wr_stb && reg_sel[0])));
endmodule

bind char_io_regs char_io_regs_chk #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .key_stb    (key_stb),
    .disp_done  (disp_done),
    .disp_valid (disp_valid),
    .disp_char  (disp_char),
    .kbd_irq    (kbd_irq),
    .k_rdy      (k_rdy),
    .k_ie       (k_ie),
    .d_rdy      (d_rdy)
);

// File: tb/sim_char_io_regs.sv
module sim_char_io_regs;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        key_stb = 1'b0;
    logic [7:0]  key_char = '0;
    logic        disp_done = 1'b0;
    logic        disp_valid;
    logic [7:0]  disp_char;
    logic        kbd_irq, dsp_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    char_io_regs u0 (.*);

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Read one register; the clearing read strobe is applied.
    task automatic bus_read(input int idx, output logic [15:0] val);
        @(negedge clk);
        reg_sel = 4'b1 << idx; rd_stb = 1'b1;
        #1 val = rd_data;
        @(negedge clk);
        reg_sel = '0; rd_stb = 1'b0;
    endtask

    // Write one register; returns at the negedge after the capturing edge.
    task automatic bus_write(input int idx, input logic [15:0] val);
        @(negedge clk);
        reg_sel = 4'b1 << idx; wr_stb = 1'b1; wr_data = val;
        @(negedge clk);
        reg_sel = '0; wr_stb = 1'b0; wr_data = '0;
    endtask

    task automatic strike(input logic [7:0] c);
        @(negedge clk);
        key_stb = 1'b1; key_char = c;
        @(negedge clk);
        key_stb = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 kbd_irq", {15'b0, kbd_irq}, 16'h0);
        chk("R1 dsp_irq", {15'b0, dsp_irq}, 16'h0);
        chk("R1 disp_valid", {15'b0, disp_valid}, 16'h0);
        bus_read(0, v); chk("R1 kbd status", v, 16'h0000);
        bus_read(2, v); chk("R1 dsp status", v, 16'h8000);
        #1 chk("R9 no select reads zero", rd_data, 16'h0000);
    endtask

    task automatic t_key();
        logic [15:0] v;
        strike(8'h41);
        bus_read(0, v); chk("R2 ready after strike", v, 16'h8000);
        bus_read(1, v); chk("R2 R9 data word", v, 16'h0041);
        bus_read(0, v); chk("R3 ready cleared by read", v, 16'h0000);
    endtask

    task automatic t_collide_key();
        logic [15:0] v;
        strike(8'h42);
        @(negedge clk);
        reg_sel = 4'b0010; rd_stb = 1'b1; key_stb = 1'b1; key_char = 8'h43;
        #1 chk("R4 read sees old char", rd_data, 16'h0042);
        @(negedge clk);
        reg_sel = '0; rd_stb = 1'b0; key_stb = 1'b0;
        bus_read(0, v); chk("R4 ready stays set", v, 16'h8000);
        bus_read(1, v); chk("R4 new char stored", v, 16'h0043);
    endtask

    task automatic t_kstatus();
        logic [15:0] v;
        bus_write(0, 16'hFFFF);
        bus_read(0, v); chk("R7 only enable written", v, 16'h4000);
        chk("R8 irq off while not ready", {15'b0, kbd_irq}, 16'h0);
        strike(8'h55);
        chk("R8 kbd irq on", {15'b0, kbd_irq}, 16'h1);
        bus_write(0, 16'h0000);
        chk("R8 kbd irq off after disable", {15'b0, kbd_irq}, 16'h0);
        bus_read(0, v); chk("R7 ready kept on status write", v, 16'h8000);
        bus_read(1, v);
    endtask

    task automatic t_display();
        logic [15:0] v;
        bus_write(3, 16'h1234);
        chk("R5 valid pulse", {15'b0, disp_valid}, 16'h1);
        chk("R5 char", {8'h00, disp_char}, 16'h0034);
        @(negedge clk);
        chk("R5 pulse one cycle", {15'b0, disp_valid}, 16'h0);
        bus_read(2, v); chk("R5 ready cleared", v, 16'h0000);
        bus_read(3, v); chk("R9 display data word", v, 16'h0034);
        bus_write(2, 16'h4000);
        chk("R8 dsp irq off while busy", {15'b0, dsp_irq}, 16'h0);
        @(negedge clk); disp_done = 1'b1;
        @(negedge clk); disp_done = 1'b0;
        chk("R8 dsp irq on", {15'b0, dsp_irq}, 16'h1);
        bus_read(2, v); chk("R6 R9 ready set by done", v, 16'hC000);
        @(negedge clk);
        reg_sel = 4'b1000; wr_stb = 1'b1; wr_data = 16'h00AA; disp_done = 1'b1;
        @(negedge clk);
        reg_sel = '0; wr_stb = 1'b0; disp_done = 1'b0;
        chk("R6 write beats done pulse", {15'b0, disp_valid}, 16'h1);
        bus_read(2, v); chk("R6 write beats done", v, 16'h4000);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_key();
        t_collide_key();
        t_kstatus();
        t_display();
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule